// File: doc/BRIEF.md
# Register-Bank Subordinate with Two-Cycle Error Response

This block is an AHB-Lite subordinate holding a small bank of 32-bit registers. Most registers can be read and written. A few, chosen by a parameter mask, hold fixed read-only values. The block rejects two kinds of access with the protocol's two-cycle error sequence: any access whose address falls inside a configurable forbidden window, and any write to a read-only register. A rejected access never changes register contents.

The block samples address-phase signals only in cycles where the bus ready input is high. This lets a manager use the stalled first cycle of an error to withdraw a transfer it had already placed on the bus. The manager does this by replacing that transfer with an IDLE phase in the second cycle, and the withdrawn transfer is never acted on.

Two counters are exposed, one for accepted transfers and one for error responses. An environment can compare them against its own expectations to confirm that idle, deselected or withdrawn phases had no effect.

Top module: `ahb_err_sub`

## Requirements
- R1: While reset is held and right after it, hreadyout_o is 1, hresp_o is 0 (OKAY), hrdata_o is 0 and both counters are 0.
- R2: An erroring access accepted at a clock edge gives one cycle with hreadyout_o=0 and hresp_o=1, then one cycle with hreadyout_o=1 and hresp_o=1, and then hresp_o=0 unless another error was accepted.
- R3: An active access (htrans_i 2'b10 or 2'b11) with haddr_i inside FORBID_LO..FORBID_HI (default 0x100..0x1FF) receives the error sequence, whether it is a read or a write, and modifies no register.
- R4: Registers whose bit is set in RO_MASK (default registers 6 and 7, at byte addresses 0x18 and 0x1C) read as RO_BASE OR their index (default 0xC0DE0006 and 0xC0DE0007). A write to one of them receives the error sequence and leaves the value unchanged.
- R5: An IDLE (2'b00) or BUSY (2'b01) phase, or any phase with hsel_i low, gets a zero-wait OKAY response and changes no register and no counter.
- R6: Address-phase inputs are ignored in every cycle where hready_i is low. A NONSEQ shown during the first error cycle and replaced by IDLE in the second cycle has no effect on registers or counters.
- R7: A valid access completes with zero wait states. Register index is haddr_i[4:2]. Write data on hwdata_i in the cycle after the address phase is stored. A read returns the register on hrdata_o in that following cycle, and hrdata_o is 0 in cycles that carry no read data phase.
- R8: xfer_cnt_o rises by one for each accepted valid access, and err_cnt_o rises by one for each accepted erroring access. Both are visible from the cycle after the address phase.
- R9: An active phase sampled in the second error cycle is accepted. An erroring one restarts the error sequence immediately, and a valid one completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsel_i | input | 1 | Subordinate select |
| htrans_i | input | 2 | Transfer type |
| haddr_i | input | ADDR_W | Byte address |
| hwrite_i | input | 1 | 1 for write |
| hwdata_i | input | DATA_W | Write data, data phase |
| hready_i | input | 1 | Bus-wide ready; address phase sampled only when high |
| hreadyout_o | output | 1 | Ready driven by this subordinate |
| hresp_o | output | 1 | 0 OKAY, 1 ERROR |
| hrdata_o | output | DATA_W | Read data |
| xfer_cnt_o | output | CNT_W | Accepted valid accesses |
| err_cnt_o | output | CNT_W | Error responses issued |

## Verification
Suppose the phase sequencer were stuck or took a wrong branch. The fault would show at once on hreadyout_o and hresp_o, in the cycle after the offending address phase: the low-ready cycle would be missing or doubled, or ERROR would persist. If the block latched an address during a stalled cycle, the effect would show one cycle later. The counter for the withdrawn transfer would tick, and after a write a later read would return the cancelled data. Pending data-phase state that is not cleared would put stale values on hrdata_o in the cycle after an idle phase. The bench compares every output in every cycle against an independent model, so each of these faults appears within one or two cycles of its cause.

// File: rtl/ahb_err_pkg.sv
package ahb_err_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    PH_OKAY   = 2'd0,
    PH_ERR_LO = 2'd1,
    PH_ERR_HI = 2'd2
  } phase_e;

  localparam logic RESP_OKAY  = 1'b0;
  localparam logic RESP_ERROR = 1'b1;

  function automatic logic is_xfer(trans_e t);
    return (t == TR_NONSEQ) || (t == TR_SEQ);
  endfunction
endpackage

// File: rtl/ahb_err_decode.sv
module ahb_err_decode #(
  parameter int ADDR_W = 12,
  parameter int NREGS  = 8,
  parameter logic [ADDR_W-1:0] FORBID_LO = 12'h100,
  parameter logic [ADDR_W-1:0] FORBID_HI = 12'h1FF,
  parameter logic [NREGS-1:0]  RO_MASK   = 8'hC0,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic              hwrite_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              deny_o
);
  logic in_win;

  assign idx_o  = haddr_i[IDX_W+1:2];
  assign in_win = (haddr_i >= FORBID_LO) && (haddr_i <= FORBID_HI);
  assign deny_o = in_win || (hwrite_i && RO_MASK[idx_o]);
endmodule

// File: rtl/ahb_err_phase.sv
module ahb_err_phase
  import ahb_err_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_acc_i,
  output logic hreadyout_o,
  output logic hresp_o
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_OKAY:   ph_d = err_acc_i ? PH_ERR_LO : PH_OKAY;
      PH_ERR_LO: ph_d = PH_ERR_HI;
      PH_ERR_HI: ph_d = err_acc_i ? PH_ERR_LO : PH_OKAY;
      default:   ph_d = PH_OKAY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_OKAY;
    else         ph_q <= ph_d;
  end

  assign hreadyout_o = (ph_q != PH_ERR_LO);
  assign hresp_o     = (ph_q == PH_OKAY) ? RESP_OKAY : RESP_ERROR;
endmodule

// File: rtl/ahb_err_regs.sv
module ahb_err_regs #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 8,
  parameter logic [NREGS-1:0]  RO_MASK = 8'hC0,
  parameter logic [DATA_W-1:0] RO_BASE = 32'hC0DE_0000,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NREGS-1:0][DATA_W-1:0] mem;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (RO_MASK[g]) begin : g_ro
      assign mem[g] = RO_BASE | DATA_W'(g);
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              q <= '0;
        else if (we_i && (widx_i == IDX_W'(g)))   q <= wdata_i;
      end
      assign mem[g] = q;
    end
  end

  assign rdata_o = mem[ridx_i];
endmodule

// File: rtl/ahb_err_sub.sv
module ahb_err_sub
  import ahb_err_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NREGS  = 8,
  parameter int CNT_W  = 16,
  parameter logic [ADDR_W-1:0] FORBID_LO = 12'h100,
  parameter logic [ADDR_W-1:0] FORBID_HI = 12'h1FF,
  parameter logic [NREGS-1:0]  RO_MASK   = 8'hC0,
  parameter logic [DATA_W-1:0] RO_BASE   = 32'hC0DE_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsel_i,
  input  logic [1:0]        htrans_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic              hwrite_i,
  input  logic [DATA_W-1:0] hwdata_i,
  input  logic              hready_i,
  output logic              hreadyout_o,
  output logic              hresp_o,
  output logic [DATA_W-1:0] hrdata_o,
  output logic [CNT_W-1:0]  xfer_cnt_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  localparam int IDX_W = $clog2(NREGS);

  logic [IDX_W-1:0]  a_idx, dp_idx_q;
  logic              deny, accept, ok_acc, err_acc;
  logic              dp_rd_q, dp_wr_q;
  logic [DATA_W-1:0] rd_data;

  ahb_err_decode #(
    .ADDR_W(ADDR_W), .NREGS(NREGS),
    .FORBID_LO(FORBID_LO), .FORBID_HI(FORBID_HI), .RO_MASK(RO_MASK)
  ) u_dec (
    .haddr_i(haddr_i), .hwrite_i(hwrite_i), .idx_o(a_idx), .deny_o(deny)
  );

  // address phase counts only when the bus is ready
  assign accept  = hsel_i && hready_i && is_xfer(trans_e'(htrans_i));
  assign ok_acc  = accept && !deny;
  assign err_acc = accept && deny;

  ahb_err_phase u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_acc_i(err_acc),
    .hreadyout_o(hreadyout_o), .hresp_o(hresp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_rd_q  <= 1'b0;
      dp_wr_q  <= 1'b0;
      dp_idx_q <= '0;
    end else if (hready_i) begin
      dp_rd_q  <= ok_acc && !hwrite_i;
      dp_wr_q  <= ok_acc && hwrite_i;
      dp_idx_q <= a_idx;
    end
  end

  ahb_err_regs #(
    .DATA_W(DATA_W), .NREGS(NREGS), .RO_MASK(RO_MASK), .RO_BASE(RO_BASE)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(dp_wr_q && hready_i), .widx_i(dp_idx_q), .wdata_i(hwdata_i),
    .ridx_i(dp_idx_q), .rdata_o(rd_data)
  );

  assign hrdata_o = dp_rd_q ? rd_data : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_cnt_o <= '0;
      err_cnt_o  <= '0;
    end else begin
      if (ok_acc)  xfer_cnt_o <= xfer_cnt_o + 1'b1;
      if (err_acc) err_cnt_o  <= err_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/ahb_err_sub_chk.sv
module ahb_err_sub_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hsel_i,
  input logic [1:0]       htrans_i,
  input logic             hready_i,
  input logic             hreadyout_o,
  input logic             hresp_o,
  input logic [CNT_W-1:0] xfer_cnt_o,
  input logic [CNT_W-1:0] err_cnt_o
);
  a_r2_low_is_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hreadyout_o |-> hresp_o);

  a_r2_low_then_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hreadyout_o |=> (hreadyout_o && hresp_o));

  a_r2_error_opens_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hresp_o) |-> !hreadyout_o);

  a_r6_stall_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_i |=> ($stable(xfer_cnt_o) && $stable(err_cnt_o)));

  a_r5_idle_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && !(hsel_i && htrans_i[1])) |=> ($stable(xfer_cnt_o) && $stable(err_cnt_o)));

  a_r8_one_counter_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && hsel_i && htrans_i[1]) |=>
      ((xfer_cnt_o != $past(xfer_cnt_o)) != (err_cnt_o != $past(err_cnt_o))));

  a_r9_err_count_with_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o != $past(err_cnt_o)) |-> (!hreadyout_o && hresp_o));
endmodule

bind ahb_err_sub ahb_err_sub_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hsel_i(hsel_i), .htrans_i(htrans_i),
  .hready_i(hready_i), .hreadyout_o(hreadyout_o), .hresp_o(hresp_o),
  .xfer_cnt_o(xfer_cnt_o), .err_cnt_o(err_cnt_o)
);

// File: tb/tb_ahb_err_sub.sv
module tb_ahb_err_sub;
  localparam logic [1:0] T_IDLE = 2'b00, T_BUSY = 2'b01, T_NS = 2'b10;

  typedef struct packed {
    logic        rdy;
    logic        resp;
    logic [31:0] rdata;
    logic [15:0] xc;
    logic [15:0] ec;
    logic [7:0]  req;
  } exp_t;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        hsel_i = 1'b0, hwrite_i = 1'b0;
  logic [1:0]  htrans_i = T_IDLE;
  logic [11:0] haddr_i = '0;
  logic [31:0] hwdata_i = '0;
  logic        hready_i, hreadyout_o, hresp_o;
  logic [31:0] hrdata_o;
  logic [15:0] xfer_cnt_o, err_cnt_o;

  assign hready_i = hreadyout_o;

  ahb_err_sub dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsel_i(hsel_i), .htrans_i(htrans_i),
    .haddr_i(haddr_i), .hwrite_i(hwrite_i), .hwdata_i(hwdata_i),
    .hready_i(hready_i), .hreadyout_o(hreadyout_o), .hresp_o(hresp_o),
    .hrdata_o(hrdata_o), .xfer_cnt_o(xfer_cnt_o), .err_cnt_o(err_cnt_o)
  );

  always #5 clk_i = ~clk_i;

  int   checks = 0, failures = 0;
  bit   done = 1'b0;
  exp_t q[$];

  // independent reference model
  logic [31:0] mregs [8];
  int          st = 0;   // 0 okay, 1 error low, 2 error high
  bit          prd = 0, pwr = 0;
  int          pidx = 0;
  logic [15:0] mxc = '0, mec = '0;

  function automatic bit denied(logic [11:0] a, logic w);
    return (a >= 12'h100 && a <= 12'h1FF) || (w && (a[4:2] == 3'd6 || a[4:2] == 3'd7));
  endfunction

  task automatic step(input logic sel, input logic [1:0] tr, input logic [11:0] a,
                      input logic w, input logic [31:0] wd, input logic [7:0] req);
    exp_t e;
    bit   hr, acc, den;
    @(posedge clk_i);
    #1;
    hsel_i = sel; htrans_i = tr; haddr_i = a; hwrite_i = w; hwdata_i = wd;
    e.rdy   = (st != 1);
    e.resp  = (st != 0);
    e.rdata = prd ? mregs[pidx] : 32'h0;
    e.xc    = mxc;
    e.ec    = mec;
    e.req   = req;
    q.push_back(e);
    hr  = (st != 1);
    if (pwr && hr) mregs[pidx] = wd;
    acc = hr && sel && tr[1];
    den = acc && denied(a, w);
    if (st == 1)  st = 2;
    else if (den) st = 1;
    else          st = 0;
    if (hr) begin
      prd  = acc && !den && !w;
      pwr  = acc && !den && w;
      pidx = int'(a[4:2]);
    end
    if (acc && !den) mxc = mxc + 1'b1;
    if (den)         mec = mec + 1'b1;
  endtask

  task automatic idle(input logic [7:0] req);
    step(1'b0, T_IDLE, 12'h0, 1'b0, 32'h0, req);
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (hreadyout_o !== e.rdy || hresp_o !== e.resp || hrdata_o !== e.rdata ||
          xfer_cnt_o !== e.xc || err_cnt_o !== e.ec) begin
        failures++;
        $display("FAIL R%0d rdy=%b resp=%b rdata=%h xc=%0d ec=%0d exp rdy=%b resp=%b rdata=%h xc=%0d ec=%0d",
                 e.req, hreadyout_o, hresp_o, hrdata_o, xfer_cnt_o, err_cnt_o,
                 e.rdy, e.resp, e.rdata, e.xc, e.ec);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mregs[i] = (i >= 6) ? (32'hC0DE_0000 | i) : 32'h0;
    repeat (2) @(posedge clk_i);
    idle(8'd1);                                      // R1 reset values
    @(negedge clk_i); rst_ni = 1'b1;
    idle(8'd1);                                      // R1 just after reset

    // R7 back-to-back writes then reads
    step(1, T_NS, 12'h000, 1, 32'h0,         8'd7);
    step(1, T_NS, 12'h004, 1, 32'h1111_1111, 8'd7);
    step(1, T_NS, 12'h000, 0, 32'h2222_2222, 8'd7);
    step(1, T_NS, 12'h004, 0, 32'h0,         8'd7);
    idle(8'd7);
    idle(8'd7);

    // R5 idle, busy and deselected phases have no effect
    step(1, T_IDLE, 12'h000, 1, 32'h0,       8'd5);
    step(1, T_BUSY, 12'h004, 1, 32'hDEAD,    8'd5);
    step(0, T_NS,   12'h000, 1, 32'hBEEF,    8'd5);
    step(1, T_NS,   12'h000, 0, 32'hCAFE,    8'd5);
    step(1, T_NS,   12'h004, 0, 32'h0,       8'd5);
    idle(8'd5);

    // R3 forbidden write and read, R2 sequence
    step(1, T_NS, 12'h104, 1, 32'h0,         8'd3);
    idle(8'd2);
    step(1, T_IDLE, 12'h0, 0, 32'hBAD0_BAD0, 8'd2);
    step(1, T_NS, 12'h1FC, 0, 32'h0,         8'd3);
    idle(8'd2);
    idle(8'd2);
    step(1, T_NS, 12'h004, 0, 32'h0,         8'd3);
    idle(8'd3);

    // R4 read-only write rejected, read returns fixed value
    step(1, T_NS, 12'h018, 1, 32'h0,         8'd4);
    idle(8'd4);
    idle(8'd4);
    step(1, T_NS, 12'h018, 0, 32'h0,         8'd4);
    step(1, T_NS, 12'h01C, 0, 32'h0,         8'd4);
    idle(8'd4);

    // R6 NONSEQ shown during stall, withdrawn with IDLE
    step(1, T_NS,   12'h10C, 1, 32'h0,       8'd6);
    step(1, T_NS,   12'h000, 1, 32'h0,       8'd6);
    step(1, T_IDLE, 12'h020, 0, 32'h0,       8'd6);
    step(0, T_IDLE, 12'h0,   0, 32'hFFFF_FFFF, 8'd6);
    step(1, T_NS,   12'h000, 0, 32'h0,       8'd6);
    idle(8'd6);

    // R9 error accepted in second error cycle restarts sequence
    step(1, T_NS, 12'h100, 0, 32'h0,         8'd9);
    idle(8'd9);
    step(1, T_NS, 12'h01C, 1, 32'h0,         8'd9);
    idle(8'd9);
    // R9 valid write accepted in second error cycle
    step(1, T_NS, 12'h008, 1, 32'h0,         8'd9);
    step(1, T_NS, 12'h008, 0, 32'h3333_3333, 8'd9);
    idle(8'd9);

    // R8 mixed stream, counters compared every cycle
    step(1, T_NS, 12'h00C, 1, 32'h0,         8'd8);
    step(1, T_NS, 12'h150, 0, 32'h4444_4444, 8'd8);
    idle(8'd8);
    step(1, T_NS, 12'h00C, 0, 32'h0,         8'd8);
    step(1, T_NS, 12'h008, 0, 32'h0,         8'd8);
    idle(8'd8);
    idle(8'd8);

    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule